// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers up to four banks of 32 level-sensitive interrupt lines and presents them to a processor through a word-addressed register port. A line counts as pending while its live input is high or its software-request bit is set. Nothing is latched from the input itself, so a pending bit falls as soon as both sources are low. Each line has a mask bit, a 6-bit priority and a steering bit. The steering bit sends the line to the normal output `irq_o` or to the fast output `fiq_o`.

Each path runs its own arbiter. When a path is armed, the global enable is on and at least one unmasked line is steered to it, the path raises its output and latches the number of the winning line. The output and the latched number then stay fixed until software re-arms that path through the control register. Masks and software requests each have a write-1-to-set register and a write-1-to-clear register. The register map also provides a raw input view, a pending view for each path, a soft reset with a status word that always reports completion, and two idle-configuration fields.

Top module: `intc_top`

## Requirements
- R1: After reset every mask bit reads 1. The software, steering and priority state, the global-disable bit and both latched codes read 0. Both outputs are low.
- R2: A line's pending bit is its input ORed with its software bit. At bank base B = 0x80 + 0x20*bank, word B+0x00 shows the live inputs. Word B+0x18 shows pending AND NOT mask AND NOT steer. Word B+0x1C shows pending AND NOT mask AND steer. Bit i of each word is line 32*bank+i.
- R3: A write to B+0x04 loads the mask. A write to B+0x08 clears the mask bits written as 1, and a write to B+0x0C sets them. All three can be read back at B+0x04.
- R4: A write to B+0x10 sets the software bits written as 1, and a write to B+0x14 clears them. B+0x10 reads back the software bits.
- R5: The line-config word at 0x100 + 4*line holds the priority in bits [7:2] and the steering bit (1 = fast path) in bit 0. All other bits read 0.
- R6: Among the eligible lines, the lowest priority value wins. On equal values the higher line number wins. The latched winner reads at 0x40 for the normal path and at 0x44 for the fast path.
- R7: An armed path raises its output on the clock edge after it sees an eligible line, then disarms. The output and the code hold until a control write (0x48) with bit 0 (normal) or bit 1 (fast) set. That write drops the output at its own edge and re-arms the path, so the path can fire again on the next edge.
- R8: Control bit 2 disables new assertions on both paths while set. It reads back at 0x48 bit 2.
- R9: A write to 0x10 with bit 1 set returns all state to the R1 values, except the idle word. Bit 0 of the same write is stored and reads back at 0x10 bit 0. The word at 0x50 stores and returns its low two bits, and soft reset leaves it unchanged.
- R10: Word 0x14 always reads 1 and word 0x00 reads the REVISION parameter. Writes to 0x00, 0x14, 0x40, 0x44, B+0x00, B+0x18 and B+0x1C change nothing.
- R11: Read data appears on `rdata_o` the cycle after the request and holds until the next read. Unmapped words, banks beyond NBANK and lines beyond the last line read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 10 | Word address (byte address bits 11:2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| line_i | input | 32*NBANK | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal-path interrupt request |
| fiq_o | output | 1 | Fast-path interrupt request |

## Verification
The bench builds the block with NBANK = 2, which gives 64 lines. With that size every line can be swept one at a time through the raw and pending views, and every line-config word can be written and read back. The bench sets priorities to (line*5) mod 8, so many lines share a value. Pseudo-random multi-line patterns therefore exercise the tie rule across both banks, with the winner computed arithmetically in the bench. The third bank region and the config word of line 64 stay outside the map, so the bench can also check that they read 0.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned PRIO_W = 6;

  // word addresses (byte address >> 2)
  localparam logic [9:0] W_REV     = 10'h000;
  localparam logic [9:0] W_SYSCFG  = 10'h004;
  localparam logic [9:0] W_SYSSTAT = 10'h005;
  localparam logic [9:0] W_CODE_N  = 10'h010;
  localparam logic [9:0] W_CODE_F  = 10'h011;
  localparam logic [9:0] W_CTRL    = 10'h012;
  localparam logic [9:0] W_IDLE    = 10'h014;
  localparam logic [9:0] W_LINE0   = 10'h040;

  typedef enum logic [2:0] {
    B_RAW, B_MASK, B_MCLR, B_MSET, B_SSET, B_SCLR, B_PEND_N, B_PEND_F
  } breg_e;
endpackage

// File: rtl/intc_resolver.sv
module intc_resolver #(
  parameter int unsigned NL  = 96,
  parameter int unsigned PW  = 6,
  parameter int unsigned IDW = 7
) (
  input  logic [NL-1:0]    elig_i,
  input  logic [NL*PW-1:0] prio_i,
  output logic             any_o,
  output logic [IDW-1:0]   win_o
);
  logic [PW-1:0] best;

  // ascending scan with <= : lower value wins, ties go to higher index
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '0;
    for (int i = 0; i < NL; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PW +: PW] <= best)) begin
        any_o = 1'b1;
        best  = prio_i[i*PW +: PW];
        win_o = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_path.sv
module intc_path #(
  parameter int unsigned NL  = 96,
  parameter int unsigned PW  = 6,
  parameter int unsigned IDW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic [NL-1:0]    elig_i,
  input  logic [NL*PW-1:0] prio_i,
  input  logic             gen_en_i,
  input  logic             rearm_i,
  output logic             out_o,
  output logic [IDW-1:0]   code_o
);
  logic           any;
  logic [IDW-1:0] win;
  logic           armed_q;

  intc_resolver #(.NL(NL), .PW(PW), .IDW(IDW)) i_resolver (
    .elig_i(elig_i), .prio_i(prio_i), .any_o(any), .win_o(win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o   <= 1'b0;
      armed_q <= 1'b1;
      code_o  <= '0;
    end else if (soft_rst_i) begin
      out_o   <= 1'b0;
      armed_q <= 1'b1;
      code_o  <= '0;
    end else if (rearm_i) begin
      out_o   <= 1'b0;
      armed_q <= 1'b1;
    end else if (armed_q && any && gen_en_i) begin
      out_o   <= 1'b1;
      armed_q <= 1'b0;
      code_o  <= win;
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank import intc_pkg::*; #(
  parameter int unsigned PW = PRIO_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                soft_rst_i,
  input  logic                wr_i,
  input  logic                breg_sel_i,
  input  logic [2:0]          breg_i,
  input  logic                line_sel_i,
  input  logic [4:0]          lidx_i,
  input  logic [31:0]         wdata_i,
  input  logic [BANK_W-1:0]   src_i,
  output logic [BANK_W-1:0]   elig_n_o,
  output logic [BANK_W-1:0]   elig_f_o,
  output logic [BANK_W*PW-1:0] prio_o,
  output logic [31:0]         rdata_o
);
  logic [BANK_W-1:0] mask_q, swi_q, steer_q;
  logic [PW-1:0]     prio_q [BANK_W];
  logic [BANK_W-1:0] pend, act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (soft_rst_i) begin
      mask_q <= '1;
      swi_q  <= '0;
    end else if (wr_i && breg_sel_i) begin
      unique case (breg_e'(breg_i))
        B_MASK:  mask_q <= wdata_i;
        B_MCLR:  mask_q <= mask_q & ~wdata_i;
        B_MSET:  mask_q <= mask_q | wdata_i;
        B_SSET:  swi_q  <= swi_q | wdata_i;
        B_SCLR:  swi_q  <= swi_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q <= '0;
      for (int i = 0; i < BANK_W; i++) prio_q[i] <= '0;
    end else if (soft_rst_i) begin
      steer_q <= '0;
      for (int i = 0; i < BANK_W; i++) prio_q[i] <= '0;
    end else if (wr_i && line_sel_i) begin
      prio_q[lidx_i]  <= wdata_i[PW+1:2];
      steer_q[lidx_i] <= wdata_i[0];
    end
  end

  assign pend     = src_i | swi_q;
  assign act      = pend & ~mask_q;
  assign elig_n_o = act & ~steer_q;
  assign elig_f_o = act & steer_q;

  for (genvar i = 0; i < BANK_W; i++) begin : g_prio
    assign prio_o[i*PW +: PW] = prio_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (breg_sel_i) begin
      unique case (breg_e'(breg_i))
        B_RAW:    rdata_o = src_i;
        B_MASK:   rdata_o = mask_q;
        B_SSET:   rdata_o = swi_q;
        B_PEND_N: rdata_o = elig_n_o;
        B_PEND_F: rdata_o = elig_f_o;
        default:  rdata_o = '0;
      endcase
    end else if (line_sel_i) begin
      rdata_o = {{(30-PW){1'b0}}, prio_q[lidx_i], 1'b0, steer_q[lidx_i]};
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top import intc_pkg::*; #(
  parameter int unsigned NBANK    = 3,
  parameter logic [31:0] REVISION = 32'h0000_0021,
  localparam int unsigned NL      = NBANK * BANK_W,
  localparam int unsigned IDW     = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [11:2]   addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [NL-1:0] line_i,
  output logic          irq_o,
  output logic          fiq_o
);
  logic wr, rd, is_breg, is_line, ctrl_wr, sys_wr, idle_wr, soft_rst;
  logic [9:0] line_off;
  logic gmask_q, autoidle_q, gen_en;
  logic [1:0] idle_q;
  logic [NL-1:0]    elig_n, elig_f;
  logic [NL*PRIO_W-1:0] prio_flat;
  logic [31:0]      bank_rd [NBANK];
  logic [31:0]      bank_or, rd_mux;
  logic [NL-1:0]    elig_a  [2];
  logic             rearm_a [2];
  logic             out_a   [2];
  logic [IDW-1:0]   code_a  [2];
  logic [IDW-1:0]   code_n;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign is_breg  = (addr_i[11:7] == 5'b00001);
  assign line_off = addr_i - W_LINE0;
  assign is_line  = (addr_i >= W_LINE0) && (line_off < 10'(NL));
  assign ctrl_wr  = wr && (addr_i == W_CTRL);
  assign sys_wr   = wr && (addr_i == W_SYSCFG);
  assign idle_wr  = wr && (addr_i == W_IDLE);
  assign soft_rst = sys_wr && wdata_i[1];
  assign gen_en   = !gmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= '0;
    end else begin
      if (soft_rst)     gmask_q <= 1'b0;
      else if (ctrl_wr) gmask_q <= wdata_i[2];
      if (sys_wr)       autoidle_q <= wdata_i[0];
      if (idle_wr)      idle_q <= wdata_i[1:0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.PW(PRIO_W)) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .wr_i       (wr),
      .breg_sel_i (is_breg && (32'(addr_i[6:5]) == b)),
      .breg_i     (addr_i[4:2]),
      .line_sel_i (is_line && (32'(line_off[9:5]) == b)),
      .lidx_i     (line_off[4:0]),
      .wdata_i    (wdata_i),
      .src_i      (line_i[b*BANK_W +: BANK_W]),
      .elig_n_o   (elig_n[b*BANK_W +: BANK_W]),
      .elig_f_o   (elig_f[b*BANK_W +: BANK_W]),
      .prio_o     (prio_flat[b*BANK_W*PRIO_W +: BANK_W*PRIO_W]),
      .rdata_o    (bank_rd[b])
    );
  end

  assign elig_a[0]  = elig_n;
  assign elig_a[1]  = elig_f;
  assign rearm_a[0] = ctrl_wr && wdata_i[0];
  assign rearm_a[1] = ctrl_wr && wdata_i[1];

  for (genvar p = 0; p < 2; p++) begin : g_path
    intc_path #(.NL(NL), .PW(PRIO_W), .IDW(IDW)) i_path (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst),
      .elig_i     (elig_a[p]),
      .prio_i     (prio_flat),
      .gen_en_i   (gen_en),
      .rearm_i    (rearm_a[p]),
      .out_o      (out_a[p]),
      .code_o     (code_a[p])
    );
  end

  assign irq_o  = out_a[0];
  assign fiq_o  = out_a[1];
  assign code_n = code_a[0];

  always_comb begin
    bank_or = '0;
    for (int b = 0; b < NBANK; b++) bank_or |= bank_rd[b];
  end

  always_comb begin
    unique case (addr_i)
      W_REV:     rd_mux = REVISION;
      W_SYSCFG:  rd_mux = {31'b0, autoidle_q};
      W_SYSSTAT: rd_mux = 32'h1;
      W_CODE_N:  rd_mux = 32'(code_a[0]);
      W_CODE_F:  rd_mux = 32'(code_a[1]);
      W_CTRL:    rd_mux = {29'b0, gmask_q, 2'b0};
      W_IDLE:    rd_mux = {30'b0, idle_q};
      default:   rd_mux = bank_or;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned NL  = 96,
  parameter int unsigned IDW = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [11:2]    addr_i,
  input logic [1:0]     wdata_i,
  input logic [31:0]    rdata_o,
  input logic           irq_o,
  input logic           fiq_o,
  input logic [NL-1:0]  elig_n_i,
  input logic           gen_en_i,
  input logic [IDW-1:0] code_n_i
);
  logic ctrl_w, sys_w, rearm_n, rearm_f, srst, stat_rd;
  assign ctrl_w  = req_i && we_i && (addr_i == 10'h012);
  assign sys_w   = req_i && we_i && (addr_i == 10'h004);
  assign rearm_n = ctrl_w && wdata_i[0];
  assign rearm_f = ctrl_w && wdata_i[1];
  assign srst    = sys_w && wdata_i[1];
  assign stat_rd = req_i && !we_i && (addr_i == 10'h005);

  p_fire_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((|elig_n_i) && gen_en_i));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rearm_n && !srst |=> irq_o);
  p_code_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rearm_n && !srst |=> $stable(code_n_i));
  p_rearm_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_n |=> !irq_o);
  p_fast_rearm_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_f |=> !fiq_o);
  p_gmask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i && !irq_o |=> !irq_o);
  p_status_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> rdata_o == 32'h1);
  p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> !irq_o && !fiq_o);
endmodule

bind intc_top intc_checker #(.NL(NL), .IDW(IDW)) i_intc_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i[1:0]),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .fiq_o    (fiq_o),
  .elig_n_i (elig_n),
  .gen_en_i (gen_en),
  .code_n_i (code_n)
);

// File: tb/test_intc_top.sv
module test_intc_top;
  localparam int CLK_P = 10;
  localparam int NB = 2;
  localparam int NL = NB * 32;
  localparam logic [31:0] REV = 32'h0000_0021;

  logic clk = 1'b0, rst_ni = 1'b0, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NL-1:0] lines = '0;
  logic irq, fiq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  intc_top #(.NBANK(NB), .REVISION(REV)) i_intc_top (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr[11:2]),
    .wdata_i(wdata), .rdata_o(rdata), .line_i(lines), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  function automatic int prio_of(input int l);
    return (l * 5) % 8;
  endfunction

  function automatic int win_of(input logic [NL-1:0] p);
    int w = 0, bp = 0;
    bit f = 1'b0;
    for (int l = 0; l < NL; l++)
      if (p[l] && (!f || prio_of(l) <= bp)) begin f = 1'b1; bp = prio_of(l); w = l; end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] x, pat;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);
    rd(12'h084, d); chk("R1 mask0", d, 32'hFFFF_FFFF);
    rd(12'h0A4, d); chk("R1 mask1", d, 32'hFFFF_FFFF);
    rd(12'h090, d); chk("R1 swi", d, 0);
    rd(12'h040, d); chk("R1 code", d, 0);
    rd(12'h048, d); chk("R1 ctrl", d, 0);
    rd(12'h100, d); chk("R1 linecfg", d, 0);
    rd(12'h014, d); chk("R10 status", d, 1);
    rd(12'h000, d); chk("R10 rev", d, REV);

    // R2 raw view sweep, all masked
    for (int l = 0; l < NL; l++) begin
      lines = 64'(1) << l;
      rd(12'(12'h080 + 32 * (l / 32)), d); chk("R2 raw", d, 32'(1) << (l % 32));
      rd(12'(12'h098 + 32 * (l / 32)), d); chk("R2 masked view", d, 0);
    end

    // R3 mask registers
    wr(12'h088, 32'hFFFF_FFFF); wr(12'h0A8, 32'hFFFF_FFFF);
    rd(12'h084, d); chk("R3 mclr", d, 0);
    wr(12'h08C, 32'h0000_00F0);
    rd(12'h084, d); chk("R3 mset", d, 32'h0000_00F0);
    wr(12'h084, 32'h0);
    rd(12'h084, d); chk("R3 mload", d, 0);

    // R5 line config sweep
    for (int l = 0; l < NL; l++)
      wr(12'(12'h100 + 4 * l), 32'hFF00_0002 | (32'((l * 37) % 64) << 2) | 32'(l & 1));
    for (int l = 0; l < NL; l++) begin
      rd(12'(12'h100 + 4 * l), d);
      chk("R5 linecfg", d, (32'((l * 37) % 64) << 2) | 32'(l & 1));
    end
    for (int l = 0; l < NL; l++) wr(12'(12'h100 + 4 * l), 32'(prio_of(l)) << 2);

    // R2 split views
    wr(12'h1A0, 32'h1);
    lines = (64'(1) << 40) | (64'(1) << 3);
    rd(12'h098, d); chk("R2 pend_n b0", d, 32'h8);
    rd(12'h0B8, d); chk("R2 pend_n b1", d, 0);
    rd(12'h0BC, d); chk("R2 pend_f b1", d, 32'h100);
    rd(12'h09C, d); chk("R2 pend_f b0", d, 0);
    wr(12'h0AC, 32'h100);
    rd(12'h0BC, d); chk("R3 mask hides", d, 0);
    rd(12'h0A4, d); chk("R3 mset b1", d, 32'h100);
    wr(12'h0A8, 32'h100);
    rd(12'h0A4, d); chk("R3 mclr b1", d, 0);
    wr(12'h1A0, 32'(prio_of(40)) << 2);

    // R6 R7 winner over patterns
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 40; k++) begin
      if (k == 0) pat = '0;
      else if (k == 1) pat = '1;
      else begin
        x ^= x << 13; x ^= x >> 7; x ^= x << 17;
        pat = x & (x >> 11) & (x >> 23);
      end
      lines = pat;
      wr(12'h048, 32'h1);
      chk("R7 rearm drop", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R7 fire", {31'b0, irq}, {31'b0, pat != 0});
      if (pat != 0) begin
        rd(12'h040, d); chk("R6 code", d, 32'(win_of(pat)));
      end
    end
    // R7 hold while inputs change
    rd(12'h040, d);
    lines = '1;
    repeat (3) @(negedge clk);
    chk("R7 hold", {31'b0, irq}, 1);
    begin
      logic [31:0] d2;
      rd(12'h040, d2); chk("R7 code held", d2, d);
    end

    // R8 global disable
    lines = 64'(1) << 10;
    wr(12'h048, 32'h5);
    repeat (3) @(negedge clk);
    chk("R8 blocked", {31'b0, irq}, 0);
    rd(12'h048, d); chk("R8 readback", d, 32'h4);
    wr(12'h048, 32'h0);
    chk("R8 not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R8 released", {31'b0, irq}, 1);
    rd(12'h040, d); chk("R8 code", d, 10);

    // R4 software requests
    lines = '0;
    wr(12'h048, 32'h1);
    wr(12'h090, 32'h1000);
    rd(12'h090, d); chk("R4 sset", d, 32'h1000);
    rd(12'h098, d); chk("R2 sw pending", d, 32'h1000);
    chk("R4 fire", {31'b0, irq}, 1);
    rd(12'h040, d); chk("R4 code", d, 12);
    wr(12'h0B0, 32'h1);
    rd(12'h0B8, d); chk("R4 sset b1", d, 32'h1);
    wr(12'h094, 32'h1000);
    rd(12'h090, d); chk("R4 sclr", d, 0);
    rd(12'h098, d); chk("R2 cleared", d, 0);
    lines[12] = 1'b1;
    rd(12'h098, d); chk("R2 input only", d, 32'h1000);
    wr(12'h0B4, 32'h1);
    rd(12'h0B0, d); chk("R4 sclr b1", d, 0);
    lines = '0;

    // R6 R7 fast path with tie
    wr(12'h150, 32'h1);
    wr(12'h154, 32'h1);
    lines = (64'(1) << 20) | (64'(1) << 21);
    wr(12'h048, 32'h2);
    chk("R7 fast drop", {31'b0, fiq}, 0);
    @(negedge clk);
    chk("R7 fast fire", {31'b0, fiq}, 1);
    rd(12'h044, d); chk("R6 fast tie", d, 21);
    wr(12'h048, 32'h1);
    @(negedge clk);
    chk("R2 steer off normal", {31'b0, irq}, 0);
    lines[21] = 1'b0;
    @(negedge clk);
    rd(12'h044, d); chk("R7 fast held", d, 21);
    chk("R7 fast out held", {31'b0, fiq}, 1);

    // R10 read-only writes ignored
    wr(12'h040, 32'h55); rd(12'h040, d); chk("R10 code_n", d, 12);
    wr(12'h044, 32'h55); rd(12'h044, d); chk("R10 code_f", d, 21);
    wr(12'h014, 32'h0);  rd(12'h014, d); chk("R10 status", d, 1);
    wr(12'h098, 32'hFFFF_FFFF); rd(12'h098, d); chk("R10 pend_n", d, 0);
    wr(12'h09C, 32'h0); rd(12'h09C, d); chk("R10 pend_f", d, 32'h0010_0000);
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, d); chk("R10 raw", d, 32'h0010_0000);
    wr(12'h000, 32'h0); rd(12'h000, d); chk("R10 rev", d, REV);

    // R11 unmapped and hold
    rd(12'h0C0, d); chk("R11 bank2", d, 0);
    rd(12'h200, d); chk("R11 line64", d, 0);
    rd(12'h030, d); chk("R11 hole", d, 0);
    rd(12'h1FC, d); chk("R11 line63", d, 32'(prio_of(63)) << 2);
    repeat (3) @(negedge clk);
    chk("R11 hold", rdata, 32'(prio_of(63)) << 2);

    // R9 soft reset and idle config
    wr(12'h050, 32'h7);
    rd(12'h050, d); chk("R9 idle", d, 3);
    wr(12'h048, 32'h4);
    wr(12'h010, 32'h3);
    chk("R9 irq", {31'b0, irq}, 0);
    chk("R9 fiq", {31'b0, fiq}, 0);
    rd(12'h010, d); chk("R9 autoidle", d, 1);
    rd(12'h084, d); chk("R9 mask", d, 32'hFFFF_FFFF);
    rd(12'h154, d); chk("R9 linecfg", d, 0);
    rd(12'h044, d); chk("R9 code_f", d, 0);
    rd(12'h048, d); chk("R9 ctrl", d, 0);
    rd(12'h050, d); chk("R9 idle kept", d, 3);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule